// File: doc/BRIEF.md
# Motion-Detect Interrupt Latch Controller

This block turns short per-axis motion strobes into two sticky interrupt flags and drives them onto two output pins. Upstream detectors deliver, per axis, a level hit (as a magnitude compare and as a signed compare), a single-pulse hit and a pulse-detection hit. A two-bit source code in the control register chooses which kind of event feeds each flag. Per-axis disable bits mask individual axes. A swap bit exchanges the two pins.

Software reaches the block through a simple register port with a write strobe, a write address, write data and a combinational read address and data. Besides the two flags, the block keeps per-axis source bits that show which axis and which detector kind fired. A flag is cleared by setting its bit in the clear register and then writing the bit back to zero. For as long as the bit stays at one, the flag and its source bits are held at zero.

Double-pulse operation is in effect when the second-pulse window register is nonzero and the single-pulse source code is selected. In that case the first flag ignores its own clear bit. The second clear bit then clears both flags and raises a restart output, which tells the upstream pulse sequencer to start over.

Top module: `mdet_irq_latch`

## Requirements
- R1: After reset, the control, clear and window registers, both flags, all source bits and both pins are 0.
- R2: With source code 00 in control bits 2:1, flag 1 latches on a level hit from any enabled axis and flag 2 latches on a pulse-detection hit.
- R3: Source code 01 makes flag 1 follow pulse-detection hits and flag 2 follow level hits. Code 11 behaves exactly like code 00.
- R4: Source code 10 makes flag 1 follow single-pulse hits and flag 2 follow pulse-detection hits.
- R5: Control bits 3, 4 and 5 disable axis X, Y and Z respectively. A disabled axis sets no flag and no source bit.
- R6: Control bit 6 selects which compare feeds level hits: the magnitude compare input at 0, the signed compare input at 1. The other compare input has no effect.
- R7: A set flag stays set, with no further hits, until its clear takes effect.
- R8: The clear register sits at address 1, with bit 0 for flag 1 and bit 1 for flag 2 (other bits read 0). While a clear bit is 1, that flag and the source bits of the event kind feeding it are held at 0 and do not re-latch. Latching resumes in the cycle after the bit returns to 0.
- R9: When the window register at address 2 is nonzero and the source code is 10, clear bit 0 has no effect. Clear bit 1 then clears both flags and all pulse source bits, and holds the restart output high while it is 1.
- R10: With control bit 0 at 0, pin 1 shows flag 1 and pin 2 shows flag 2. With the bit at 1, pin 1 shows flag 2 and pin 2 shows flag 1.
- R11: The source register at address 3 holds the level bits for X, Y and Z in bits 2:0 and the pulse bits in bits 5:3. A bit is set only by an event kind that currently feeds a flag, and it stays set until cleared.
- R12: Address 0 reads back all 8 control bits and address 2 the window. Address 4 shows flag 1 in bit 0 and flag 2 in bit 1. Writes to addresses 3 and 4 are ignored, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| lvl_abs_i | input | 3 | Per-axis level hit, magnitude compare |
| lvl_sgn_i | input | 3 | Per-axis level hit, signed compare |
| pls_single_i | input | 3 | Per-axis single-pulse hit |
| pls_event_i | input | 3 | Per-axis pulse-detection hit |
| irq_pin1_o | output | 1 | Interrupt pin 1 |
| irq_pin2_o | output | 1 | Interrupt pin 2 |
| dp_restart_o | output | 1 | Restart request to the pulse sequencer |

## Verification
The bench probes the clear rules hardest. It fires hits while a clear bit is held at 1, which a design with an edge-only clear would let re-latch. It sets clear bit 0 under double-pulse operation, where a design missing the lock would drop flag 1. It also sets clear bit 1 there, where a design without the rule would leave flag 1 set and keep the restart output low. It drives hits on disabled axes and on the unselected threshold input, and a wrong mask or mux shows up as a spurious flag or source bit. It exercises codes 01, 10 and 11 and the pin swap, where a mis-decoded code or swapped routing puts the flag on the wrong pin.

// File: rtl/mdet_pkg.sv
package mdet_pkg;
   localparam int ADDR_CTRL  = 0;
   localparam int ADDR_CLR   = 1;
   localparam int ADDR_WIN   = 2;
   localparam int ADDR_SRC   = 3;
   localparam int ADDR_FLAG  = 4;

   localparam int SWAP_BIT   = 0;
   localparam int SEL_LSB    = 1;
   localparam int DIS_LSB    = 3;
   localparam int THR_BIT    = 6;

   typedef enum logic [1:0] {
      EVK_LEVEL  = 2'd0,
      EVK_PULSE  = 2'd1,
      EVK_SINGLE = 2'd2
   } evt_kind_e;

   // which = 0 -> flag 1, which = 1 -> flag 2
   function automatic evt_kind_e kind_of(input logic [1:0] sel, input logic which);
      evt_kind_e k;
      case (sel)
         2'b01:   k = which ? EVK_LEVEL : EVK_PULSE;
         2'b10:   k = which ? EVK_PULSE : EVK_SINGLE;
         default: k = which ? EVK_PULSE : EVK_LEVEL;
      endcase
      return k;
   endfunction
endpackage

// File: rtl/mdet_evt_sel.sv
module mdet_evt_sel
   import mdet_pkg::*;
#(
   parameter int NAXES = 3
) (
   input  logic [1:0]       sel_i,
   input  logic [NAXES-1:0] dis_i,
   input  logic             thr_signed_i,
   input  logic [NAXES-1:0] lvl_abs_i,
   input  logic [NAXES-1:0] lvl_sgn_i,
   input  logic [NAXES-1:0] pls_single_i,
   input  logic [NAXES-1:0] pls_event_i,
   output logic [NAXES-1:0] lvl_m_o,
   output logic [NAXES-1:0] sgl_m_o,
   output logic [NAXES-1:0] pev_m_o,
   output logic [1:0]       flag_hit_o
);
   for (genvar a = 0; a < NAXES; a++) begin : g_axis
      always_comb begin
         lvl_m_o[a] = ~dis_i[a] & (thr_signed_i ? lvl_sgn_i[a] : lvl_abs_i[a]);
         sgl_m_o[a] = ~dis_i[a] & pls_single_i[a];
         pev_m_o[a] = ~dis_i[a] & pls_event_i[a];
      end
   end

   for (genvar f = 0; f < 2; f++) begin : g_flag
      always_comb begin
         case (kind_of(sel_i, f[0]))
            EVK_LEVEL:  flag_hit_o[f] = |lvl_m_o;
            EVK_SINGLE: flag_hit_o[f] = |sgl_m_o;
            default:    flag_hit_o[f] = |pev_m_o;
         endcase
      end
   end
endmodule

// File: rtl/mdet_flag_latch.sv
module mdet_flag_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (clr_i) flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
   end
endmodule

// File: rtl/mdet_regs.sv
module mdet_regs
   import mdet_pkg::*;
#(
   parameter int DW    = 8,
   parameter int AW    = 3,
   parameter int NAXES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   input  logic [NAXES-1:0] src_lvl_i,
   input  logic [NAXES-1:0] src_pls_i,
   input  logic [1:0]       flag_i,
   output logic [DW-1:0]    rd_data,
   output logic [DW-1:0]    ctrl_o,
   output logic [1:0]       clr_o,
   output logic [DW-1:0]    win_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '0;
         clr_o  <= '0;
         win_o  <= '0;
      end else if (wr_en) begin
         case (int'(wr_addr))
            ADDR_CTRL: ctrl_o <= wr_data;
            ADDR_CLR:  clr_o  <= wr_data[1:0];
            ADDR_WIN:  win_o  <= wr_data;
            default:   ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (int'(rd_addr))
         ADDR_CTRL: rd_data = ctrl_o;
         ADDR_CLR:  rd_data[1:0] = clr_o;
         ADDR_WIN:  rd_data = win_o;
         ADDR_SRC:  rd_data[2*NAXES-1:0] = {src_pls_i, src_lvl_i};
         ADDR_FLAG: rd_data[1:0] = flag_i;
         default:   ;
      endcase
   end
endmodule

// File: rtl/mdet_irq_latch.sv
module mdet_irq_latch
   import mdet_pkg::*;
#(
   parameter int DW    = 8,
   parameter int AW    = 3,
   parameter int NAXES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data,
   input  logic [NAXES-1:0] lvl_abs_i,
   input  logic [NAXES-1:0] lvl_sgn_i,
   input  logic [NAXES-1:0] pls_single_i,
   input  logic [NAXES-1:0] pls_event_i,
   output logic             irq_pin1_o,
   output logic             irq_pin2_o,
   output logic             dp_restart_o
);
   localparam int SRC_W = 2 * NAXES;

   if (NAXES < 1 || DIS_LSB + NAXES > THR_BIT) begin : g_bad_axes
      $error("mdet_irq_latch: NAXES must be 1..3");
   end
   if (DW < 8 || SRC_W > DW) begin : g_bad_dw
      $error("mdet_irq_latch: DW must be at least 8");
   end
   if ((1 << AW) <= ADDR_FLAG) begin : g_bad_aw
      $error("mdet_irq_latch: AW too narrow for register map");
   end

   logic [DW-1:0]    ctrl_q;
   logic [DW-1:0]    win_q;
   logic [1:0]       clr_q;
   logic [1:0]       flag_q;
   logic [1:0]       clr_eff;
   logic [1:0]       flag_hit;
   logic [NAXES-1:0] lvl_m, sgl_m, pev_m;
   logic [NAXES-1:0] src_lvl_q, src_pls_q;
   logic [1:0]       sel;
   logic             dp_lock;
   evt_kind_e        kind [2];
   logic             lvl_used, sgl_used, pev_used;
   logic             clr_lvl, clr_pls;

   mdet_regs #(.DW(DW), .AW(AW), .NAXES(NAXES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .src_lvl_i (src_lvl_q),
      .src_pls_i (src_pls_q),
      .flag_i    (flag_q),
      .rd_data   (rd_data),
      .ctrl_o    (ctrl_q),
      .clr_o     (clr_q),
      .win_o     (win_q)
   );

   assign sel = ctrl_q[SEL_LSB +: 2];

   mdet_evt_sel #(.NAXES(NAXES)) u_sel (
      .sel_i        (sel),
      .dis_i        (ctrl_q[DIS_LSB +: NAXES]),
      .thr_signed_i (ctrl_q[THR_BIT]),
      .lvl_abs_i    (lvl_abs_i),
      .lvl_sgn_i    (lvl_sgn_i),
      .pls_single_i (pls_single_i),
      .pls_event_i  (pls_event_i),
      .lvl_m_o      (lvl_m),
      .sgl_m_o      (sgl_m),
      .pev_m_o      (pev_m),
      .flag_hit_o   (flag_hit)
   );

   always_comb begin
      kind[0]    = kind_of(sel, 1'b0);
      kind[1]    = kind_of(sel, 1'b1);
      dp_lock    = (win_q != '0) && (kind[0] == EVK_SINGLE);
      clr_eff[1] = clr_q[1];
      clr_eff[0] = dp_lock ? clr_q[1] : clr_q[0];
      lvl_used   = (kind[0] == EVK_LEVEL)  || (kind[1] == EVK_LEVEL);
      sgl_used   = (kind[0] == EVK_SINGLE) || (kind[1] == EVK_SINGLE);
      pev_used   = (kind[0] == EVK_PULSE)  || (kind[1] == EVK_PULSE);
      clr_lvl    = (clr_eff[0] && kind[0] == EVK_LEVEL) ||
                   (clr_eff[1] && kind[1] == EVK_LEVEL);
      clr_pls    = (clr_eff[0] && kind[0] != EVK_LEVEL) ||
                   (clr_eff[1] && kind[1] != EVK_LEVEL);
   end

   for (genvar f = 0; f < 2; f++) begin : g_latch
      mdet_flag_latch u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (flag_hit[f]),
         .clr_i  (clr_eff[f]),
         .flag_o (flag_q[f])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_lvl_q <= '0;
         src_pls_q <= '0;
      end else begin
         if (clr_lvl)       src_lvl_q <= '0;
         else if (lvl_used) src_lvl_q <= src_lvl_q | lvl_m;
         if (clr_pls)       src_pls_q <= '0;
         else               src_pls_q <= src_pls_q | (sgl_used ? sgl_m : '0)
                                                   | (pev_used ? pev_m : '0);
      end
   end

   assign irq_pin1_o   = ctrl_q[SWAP_BIT] ? flag_q[1] : flag_q[0];
   assign irq_pin2_o   = ctrl_q[SWAP_BIT] ? flag_q[0] : flag_q[1];
   assign dp_restart_o = dp_lock & clr_q[1];
endmodule

// File: rtl/mdet_irq_latch_chk.sv
module mdet_irq_latch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] flag_q,
   input logic [1:0] clr_q,
   input logic       dp_lock,
   input logic       swap,
   input logic       pin1,
   input logic       pin2
);
   // R7
   f1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[0] && !clr_q[0] && !clr_q[1] |=> flag_q[0]);
   // R7
   f2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[1] && !clr_q[1] |=> flag_q[1]);
   // R8
   clr2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q[1] |=> !flag_q[1]);
   // R8
   clr1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q[0] && !dp_lock |=> !flag_q[0]);
   // R9
   dp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dp_lock && flag_q[0] && !clr_q[1] |=> flag_q[0]);
   // R9
   dp_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dp_lock && clr_q[1] |=> flag_q == 2'b00);
   // R10
   pin_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swap |-> (pin1 == flag_q[1]) && (pin2 == flag_q[0]));
   // R10
   pin_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |-> (pin1 == flag_q[0]) && (pin2 == flag_q[1]));
endmodule

bind mdet_irq_latch mdet_irq_latch_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .flag_q  (flag_q),
   .clr_q   (clr_q),
   .dp_lock (dp_lock),
   .swap    (ctrl_q[0]),
   .pin1    (irq_pin1_o),
   .pin2    (irq_pin2_o)
);

// File: tb/mdet_irq_latch_bench.sv
module mdet_irq_latch_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [2:0] lvl_abs = '0, lvl_sgn = '0, pls_single = '0, pls_event = '0;
   logic       pin1, pin2, restart;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // behavioural reference state
   logic [7:0] m_ctrl = '0, m_win = '0;
   logic [1:0] m_clr = '0;
   logic [2:0] m_lsrc = '0, m_psrc = '0;
   logic       m_f1 = 0, m_f2 = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdet_irq_latch u_mdet_irq_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .lvl_abs_i(lvl_abs), .lvl_sgn_i(lvl_sgn), .pls_single_i(pls_single),
      .pls_event_i(pls_event), .irq_pin1_o(pin1), .irq_pin2_o(pin2),
      .dp_restart_o(restart)
   );

   task automatic check(string tag, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int model_rd(logic [2:0] a);
      case (a)
         3'd0: return int'(m_ctrl);
         3'd1: return int'(m_clr);
         3'd2: return int'(m_win);
         3'd3: return int'({m_psrc, m_lsrc});
         3'd4: return int'({m_f2, m_f1});
         default: return 0;
      endcase
   endfunction

   task automatic model_step();
      logic [2:0] dis, lv, sg, ev, a1, a2;
      logic [1:0] s;
      bit lock, c1, c2, cl, cp;
      dis = m_ctrl[5:3];
      s   = m_ctrl[2:1];
      lv  = (m_ctrl[6] ? lvl_sgn : lvl_abs) & ~dis;
      sg  = pls_single & ~dis;
      ev  = pls_event & ~dis;
      lock = (m_win != 0) && (s == 2'b10);
      c2 = m_clr[1];
      c1 = lock ? m_clr[1] : m_clr[0];
      if (s == 2'b01)      begin a1 = ev; a2 = lv; cl = c2; cp = c1; end
      else if (s == 2'b10) begin a1 = sg; a2 = ev; cl = 0;  cp = c1 | c2; end
      else                 begin a1 = lv; a2 = ev; cl = c1; cp = c2; end
      m_f1 = c1 ? 1'b0 : (m_f1 | (|a1));
      m_f2 = c2 ? 1'b0 : (m_f2 | (|a2));
      if (cl) m_lsrc = '0;
      else if (s != 2'b10) m_lsrc = m_lsrc | lv;
      if (cp) m_psrc = '0;
      else m_psrc = m_psrc | ev | ((s == 2'b10) ? sg : 3'b000);
      if (wr_en) begin
         if (wr_addr == 3'd0) m_ctrl = wr_data;
         if (wr_addr == 3'd1) m_clr  = wr_data[1:0];
         if (wr_addr == 3'd2) m_win  = wr_data;
      end
   endtask

   task automatic compare_all();
      bit lock;
      lock = (m_win != 0) && (m_ctrl[2:1] == 2'b10);
      check("R10 pin1", int'(pin1), int'(m_ctrl[0] ? m_f2 : m_f1));
      check("R10 pin2", int'(pin2), int'(m_ctrl[0] ? m_f1 : m_f2));
      check("R9 restart", int'(restart), int'(lock && m_clr[1]));
      check("R12 rd_data", int'(rd_data), model_rd(rd_addr));
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      #1;
      compare_all();
      @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 0;
   endtask

   task automatic expect_rd(string tag, logic [2:0] a, int exp);
      rd_addr = a;
      #1;
      check(tag, int'(rd_data), exp);
   endtask

   task automatic clear_all();
      wr(3'd1, 8'h03);
      wr(3'd1, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_rd("R1 ctrl", 3'd0, 0);
      expect_rd("R1 flags", 3'd4, 0);
      check("R1 pins", int'({pin2, pin1}), 0);
      rst_n = 1;
      @(negedge clk);
      expect_rd("R1 src", 3'd3, 0);

      // R2: code 00, level -> flag1, pulse event -> flag2
      lvl_abs = 3'b001; tick(); lvl_abs = 0;
      expect_rd("R2 flag1 from level", 3'd4, 1);
      pls_event = 3'b010; tick(); pls_event = 0;
      tick(); tick();
      expect_rd("R7 both flags held", 3'd4, 3);
      expect_rd("R11 src bits", 3'd3, 8'h11);

      // R8: hold clear on flag1, hits ignored while held
      wr(3'd1, 8'h01);
      lvl_abs = 3'b100; tick(); tick(); lvl_abs = 0;
      expect_rd("R8 flag1 held clear", 3'd4, 2);
      expect_rd("R8 level src cleared", 3'd3, 8'h10);
      expect_rd("R8 clr readback", 3'd1, 1);
      wr(3'd1, 8'h00);
      lvl_abs = 3'b100; tick(); lvl_abs = 0;
      expect_rd("R8 relatch after release", 3'd4, 3);
      clear_all();
      expect_rd("R8 all clear", 3'd4, 0);

      // R10: pin swap
      wr(3'd0, 8'h01);
      lvl_abs = 3'b001; tick(); lvl_abs = 0;
      check("R10 swapped pins", int'({pin2, pin1}), 2'b10);
      clear_all();

      // R3: code 01 and code 11
      wr(3'd0, 8'h02);
      lvl_abs = 3'b001; tick(); lvl_abs = 0;
      expect_rd("R3 code01 level->flag2", 3'd4, 2);
      clear_all();
      wr(3'd0, 8'h06);
      lvl_abs = 3'b010; tick(); lvl_abs = 0;
      expect_rd("R3 code11 level->flag1", 3'd4, 1);
      clear_all();

      // R6: threshold mode
      wr(3'd0, 8'h40);
      lvl_abs = 3'b111; tick(); lvl_abs = 0;
      expect_rd("R6 magnitude ignored", 3'd4, 0);
      lvl_sgn = 3'b010; tick(); lvl_sgn = 0;
      expect_rd("R6 signed used", 3'd4, 1);
      clear_all();

      // R5: axis disable
      wr(3'd0, 8'h08);
      lvl_abs = 3'b001; pls_event = 3'b001; tick(); lvl_abs = 0; pls_event = 0;
      expect_rd("R5 X disabled", 3'd4, 0);
      lvl_abs = 3'b010; tick(); lvl_abs = 0;
      expect_rd("R5 Y source", 3'd3, 8'h02);
      wr(3'd0, 8'h38);
      lvl_abs = 3'b111; pls_event = 3'b111; tick(); lvl_abs = 0; pls_event = 0;
      expect_rd("R5 all disabled", 3'd3, 8'h02);
      clear_all();

      // R4: code 10
      wr(3'd0, 8'h04);
      lvl_abs = 3'b111; tick(); lvl_abs = 0;
      expect_rd("R4 level unused", 3'd4, 0);
      pls_single = 3'b100; tick(); pls_single = 0;
      expect_rd("R4 single->flag1", 3'd4, 1);
      expect_rd("R11 pulse Z src", 3'd3, 8'h20);
      pls_event = 3'b001; tick(); pls_event = 0;
      expect_rd("R4 event->flag2", 3'd4, 3);

      // R9: double-pulse lock
      wr(3'd2, 8'h05);
      wr(3'd1, 8'h01);
      tick();
      expect_rd("R9 clr1 ignored", 3'd4, 3);
      check("R9 no restart", int'(restart), 0);
      wr(3'd1, 8'h02);
      check("R9 restart high", int'(restart), 1);
      tick();
      expect_rd("R9 both cleared", 3'd4, 0);
      expect_rd("R9 pulse src cleared", 3'd3, 0);
      wr(3'd1, 8'h00);
      check("R9 restart low", int'(restart), 0);
      wr(3'd2, 8'h00);
      wr(3'd1, 8'h01);
      wr(3'd1, 8'h00);

      // R12: readback and ignored writes
      lvl_abs = 0; pls_single = 3'b010; tick(); pls_single = 0;
      wr(3'd3, 8'h00);
      wr(3'd4, 8'h00);
      expect_rd("R12 flag write ignored", 3'd4, 1);
      expect_rd("R12 src write ignored", 3'd3, 8'h10);
      wr(3'd0, 8'hA5);
      expect_rd("R12 ctrl readback", 3'd0, 8'hA5);
      expect_rd("R12 unused addr", 3'd6, 0);
      wr(3'd1, 8'hFF);
      expect_rd("R12 clr width", 3'd1, 3);
      wr(3'd1, 8'h00);
      tick();

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule